// File: doc/BRIEF.md
# Timestamp-Ordered Safe-Release Event Queue

This block sits between the inputs of a time-synchronized node (network receivers and sensor captures) and the logic that acts on events. Each incoming event carries a 64-bit time stamp and a payload. The block stores events in a small storage array that is kept sorted by time stamp. It hands out the earliest one only when the local synchronized real-time counter shows that no event with an earlier stamp can still arrive.

The release bound for the earliest stored stamp `t` is `t + s + d + e - l`. Here `s` bounds sensor delay, `d` bounds network delay, `e` bounds clock-synchronisation error, and `l` is a latency that the application grants. The bound is computed with saturation at zero. The head event leaves only while real time is strictly above that bound. The four bounds are configuration inputs. The block samples them only while it holds no event.

Released events pass through a one-entry output stage that follows ready/valid rules. Two sticky flags report trouble. One reports an input that arrived after a later-stamped event had already been released. The other reports an event handed to the consumer while its stamp was still ahead of real time.

Top module: `stamp_order_queue`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and both `order_err` and `ahead_err` are 0.
- R2: Events are handed out in non-decreasing time-stamp order, whatever order they were written in.
- R3: Events with equal stamps are handed out in the order they were accepted; their payloads identify them.
- R4: The stored event with the smallest stamp `t` moves to the output stage only at a clock edge where `now_time > t + s + d + e - l` (computed with at least 66 bits, so no overflow) and the output stage is empty or being accepted. It becomes visible on `out_valid` after that edge. While `now_time` equals the bound, it stays held.
- R5: When `l` exceeds `t + s + d + e`, the bound saturates to 0. The event is then held at `now_time == 0` and released once `now_time >= 1`.
- R6: `in_ready` is 0 exactly while the sorted storage holds DEPTH events. The output stage does not count toward this.
- R7: An input handshake whose stamp is smaller than the stamp of any event already moved to the output stage (including one moved at the same edge) discards that event. It also sets `order_err`, which stays 1 until reset.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_stamp` and `out_data` hold their values.
- R9: The four bound inputs are captured only at clock edges where both storage and output stage are empty. Changes made while any event is held have no effect on the release of those events.
- R10: A handshake at the output (`out_valid` and `out_ready` both 1) with `out_stamp > now_time` sets `ahead_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_time | input | 64 | Synchronized local real time |
| cfg_sens_dly | input | 64 | Sensor delay bound `s` |
| cfg_net_dly | input | 64 | Network delay bound `d` |
| cfg_sync_err | input | 64 | Clock error bound `e` |
| cfg_app_lat | input | 64 | Application latency `l` |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Storage can take an event |
| in_stamp | input | 64 | Input time stamp |
| in_data | input | 16 | Input payload |
| out_valid | output | 1 | Output event present |
| out_ready | input | 1 | Consumer takes the output event |
| out_stamp | output | 64 | Output time stamp |
| out_data | output | 16 | Output payload |
| order_err | output | 1 | Sticky: late-stamped input discarded |
| ahead_err | output | 1 | Sticky: event handed out before its stamp |

## Verification
Sorting is tried with ascending, descending, tie-heavy and pseudo-random arrival orders, each filling storage completely. Ascending and descending orders distinguish a working insertion point from simple FIFO or LIFO behaviour. The tie patterns separate stable insertion from insertion in front of equal stamps. The release gate is swept at the exact bound and one above it for several bound sets. One set overflows 64 bits and one saturates at zero, which separates strict from non-strict comparison, wrapped from wide arithmetic, and saturation from wrap-around. Further sequences change the bounds while events are held, stall the consumer, feed an already-passed stamp, and release an event early through a large application latency.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int unsigned TS_W  = 64;
  localparam int unsigned PL_W  = 16;
  localparam int unsigned SUM_W = TS_W + 2;

  typedef logic [TS_W-1:0] stamp_t;

  typedef struct packed {
    stamp_t            stamp;
    logic [PL_W-1:0]   data;
  } sq_entry_t;
endpackage

// File: rtl/sq_cfg_shadow.sv
module sq_cfg_shadow
  import sq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  stamp_t           sens_dly,
  input  stamp_t           net_dly,
  input  stamp_t           sync_err,
  input  stamp_t           app_lat,
  output logic [SUM_W-1:0] bound_sum,
  output stamp_t           bound_lat
);
  logic [SUM_W-1:0] sum_q, sum_d;
  stamp_t           lat_q, lat_d;

  // widen before adding so three 64-bit bounds cannot wrap
  always_comb begin
    sum_d = sum_q;
    lat_d = lat_q;
    if (load_en) begin
      sum_d = {2'b00, sens_dly} + {2'b00, net_dly} + {2'b00, sync_err};
      lat_d = app_lat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      lat_q <= '0;
    end else begin
      sum_q <= sum_d;
      lat_q <= lat_d;
    end
  end

  assign bound_sum = sum_q;
  assign bound_lat = lat_q;
endmodule

// File: rtl/sq_safe_gate.sv
module sq_safe_gate
  import sq_pkg::*;
(
  input  stamp_t           head_stamp,
  input  stamp_t           now_time,
  input  logic [SUM_W-1:0] bound_sum,
  input  stamp_t           bound_lat,
  output logic             safe
);
  logic [SUM_W-1:0] raw_bound;
  logic [SUM_W-1:0] sat_bound;
  logic [SUM_W-1:0] lat_w;

  always_comb begin
    lat_w     = {2'b00, bound_lat};
    raw_bound = {2'b00, head_stamp} + bound_sum;
    sat_bound = (raw_bound >= lat_w) ? (raw_bound - lat_w) : '0;
    safe      = ({2'b00, now_time} > sat_bound);
  end
endmodule

// File: rtl/sq_sorted_store.sv
module sq_sorted_store
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  sq_entry_t push_entry,
  input  logic      pop,
  output sq_entry_t head,
  output logic      head_valid,
  output logic      full
);
  sq_entry_t        arr_q   [DEPTH];
  sq_entry_t        arr_d   [DEPTH];
  sq_entry_t        arr_ext [DEPTH+1];
  sq_entry_t        aft     [DEPTH];
  sq_entry_t        shf     [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d, vaft, vshf, le;
  logic [DEPTH:0]   vld_ext, le_ext;

  always_comb begin
    // stage 1: drop the head when it leaves
    vld_ext        = {1'b0, vld_q};
    arr_ext[DEPTH] = '0;
    for (int i = 0; i < DEPTH; i++) arr_ext[i] = arr_q[i];
    for (int i = 0; i < DEPTH; i++) begin
      aft[i]  = pop ? arr_ext[i+1] : arr_q[i];
      vaft[i] = pop ? vld_ext[i+1] : vld_q[i];
    end
    // stage 2: slots at or below the new stamp keep place (ties stay ahead)
    for (int i = 0; i < DEPTH; i++)
      le[i] = vaft[i] && (aft[i].stamp <= push_entry.stamp);
    le_ext = {le, 1'b1};
    shf[0] = push_entry;
    for (int i = 1; i < DEPTH; i++) shf[i] = aft[i-1];
    vshf = {vaft[DEPTH-2:0], 1'b1};
    for (int i = 0; i < DEPTH; i++) begin
      if (!push || le[i]) begin
        arr_d[i] = aft[i];
        vld_d[i] = vaft[i];
      end else if (le_ext[i]) begin
        arr_d[i] = push_entry;
        vld_d[i] = 1'b1;
      end else begin
        arr_d[i] = shf[i];
        vld_d[i] = vshf[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (push || pop) vld_q <= vld_d;
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push || pop) arr_q[gi] <= arr_d[gi];
    end
  end

  assign head       = arr_q[0];
  assign head_valid = vld_q[0];
  assign full       = vld_q[DEPTH-1];
endmodule

// File: rtl/stamp_order_queue.sv
module stamp_order_queue
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now_time,
  input  logic [TS_W-1:0] cfg_sens_dly,
  input  logic [TS_W-1:0] cfg_net_dly,
  input  logic [TS_W-1:0] cfg_sync_err,
  input  logic [TS_W-1:0] cfg_app_lat,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [TS_W-1:0] in_stamp,
  input  logic [PL_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [TS_W-1:0] out_stamp,
  output logic [PL_W-1:0] out_data,
  output logic            order_err,
  output logic            ahead_err
);
  sq_entry_t        head, in_entry, os_q, os_d;
  logic             head_valid, full, safe;
  logic             take, accept_in, too_old, push, idle;
  logic             ov_q, ov_d;
  stamp_t           last_rel_q, last_rel_d;
  logic             rel_seen_q, rel_seen_d;
  logic             oerr_q, oerr_d, aerr_q, aerr_d;
  logic [SUM_W-1:0] bound_sum;
  stamp_t           bound_lat;

  assign in_entry = '{stamp: in_stamp, data: in_data};
  assign idle     = !head_valid && !ov_q;

  sq_cfg_shadow u_cfg (
    .clk(clk), .rst_n(rst_n), .load_en(idle),
    .sens_dly(cfg_sens_dly), .net_dly(cfg_net_dly),
    .sync_err(cfg_sync_err), .app_lat(cfg_app_lat),
    .bound_sum(bound_sum), .bound_lat(bound_lat)
  );

  sq_safe_gate u_gate (
    .head_stamp(head.stamp), .now_time(now_time),
    .bound_sum(bound_sum), .bound_lat(bound_lat), .safe(safe)
  );

  sq_sorted_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_entry(in_entry),
    .pop(take), .head(head), .head_valid(head_valid), .full(full)
  );

  always_comb begin
    in_ready  = !full;
    accept_in = in_valid && in_ready;
    take      = head_valid && safe && (!ov_q || out_ready);
    too_old   = (rel_seen_q && (in_stamp < last_rel_q)) ||
                (take && (in_stamp < head.stamp));
    push      = accept_in && !too_old;
  end

  always_comb begin
    ov_d       = ov_q;
    os_d       = os_q;
    last_rel_d = last_rel_q;
    rel_seen_d = rel_seen_q;
    oerr_d     = oerr_q;
    aerr_d     = aerr_q;
    if (take) begin
      ov_d       = 1'b1;
      os_d       = head;
      last_rel_d = head.stamp;
      rel_seen_d = 1'b1;
    end else if (out_ready) begin
      ov_d = 1'b0;
    end
    if (accept_in && too_old) oerr_d = 1'b1;
    if (ov_q && out_ready && (os_q.stamp > now_time)) aerr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q       <= 1'b0;
      rel_seen_q <= 1'b0;
      oerr_q     <= 1'b0;
      aerr_q     <= 1'b0;
    end else begin
      ov_q       <= ov_d;
      rel_seen_q <= rel_seen_d;
      oerr_q     <= oerr_d;
      aerr_q     <= aerr_d;
    end
  end

  // datapath registers: loaded only under their enable, no reset needed
  always_ff @(posedge clk) begin
    if (take) begin
      os_q       <= os_d;
      last_rel_q <= last_rel_d;
    end
  end

  assign out_valid = ov_q;
  assign out_stamp = os_q.stamp;
  assign out_data  = os_q.data;
  assign order_err = oerr_q;
  assign ahead_err = aerr_q;
endmodule

// File: rtl/sq_queue_chk.sv
module sq_queue_chk
  import sq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [TS_W-1:0] in_stamp,
  input logic            out_valid,
  input logic            out_ready,
  input logic [TS_W-1:0] out_stamp,
  input logic [PL_W-1:0] out_data,
  input logic [TS_W-1:0] now_time,
  input logic            order_err,
  input logic            ahead_err
);
  stamp_t last_acc_q;
  logic   acc_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_acc_q <= '0;
      acc_seen_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      last_acc_q <= out_stamp;
      acc_seen_q <= 1'b1;
    end
  end

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_stamp) && $stable(out_data));

  // R2
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && acc_seen_q |-> out_stamp >= last_acc_q);

  // R7
  a_r7_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && acc_seen_q && (in_stamp < last_acc_q) |=> order_err);

  // R10
  a_r10_ahead_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (out_stamp > now_time) |=> ahead_err);

  // R5
  a_r5_pos_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(now_time) != '0);
endmodule

bind stamp_order_queue sq_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_stamp(in_stamp), .out_valid(out_valid), .out_ready(out_ready),
  .out_stamp(out_stamp), .out_data(out_data), .now_time(now_time),
  .order_err(order_err), .ahead_err(ahead_err)
);

// File: tb/stamp_order_queue_tb.sv
module stamp_order_queue_tb;
  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic [63:0] now_time, cfg_s, cfg_d, cfg_e, cfg_l;
  logic        in_valid, in_ready, out_valid, out_ready, order_err, ahead_err;
  logic [63:0] in_stamp, out_stamp;
  logic [15:0] in_data, out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [63:0] m_st [DEPTH];
  logic [15:0] m_dt [DEPTH];
  int          m_n;

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  stamp_order_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .now_time(now_time),
    .cfg_sens_dly(cfg_s), .cfg_net_dly(cfg_d), .cfg_sync_err(cfg_e), .cfg_app_lat(cfg_l),
    .in_valid(in_valid), .in_ready(in_ready), .in_stamp(in_stamp), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_stamp(out_stamp), .out_data(out_data),
    .order_err(order_err), .ahead_err(ahead_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [63:0] s, d, e, l);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; now_time = '0;
    in_stamp = '0; in_data = '0;
    cfg_s = s; cfg_d = d; cfg_e = e; cfg_l = l;
    m_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [63:0] st, input logic [15:0] dt);
    in_stamp = st; in_data = dt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // reference: stable insertion after every equal stamp
  task automatic m_add(input logic [63:0] st, input logic [15:0] dt);
    int p = m_n;
    for (int i = 0; i < m_n; i++) if (m_st[i] > st && p == m_n) p = i;
    for (int i = m_n; i > p; i--) begin m_st[i] = m_st[i-1]; m_dt[i] = m_dt[i-1]; end
    m_st[p] = st; m_dt[p] = dt; m_n++;
  endtask

  task automatic fill(input logic [63:0] st, input logic [15:0] dt);
    push(st, dt);
    m_add(st, dt);
  endtask

  task automatic wait_out();
    int w = 0;
    while (!out_valid && w < 20) begin @(negedge clk); w++; end
  endtask

  task automatic drain_check(input string tag);
    now_time = 64'd1000;
    out_ready = 1'b1;
    for (int k = 0; k < m_n; k++) begin
      wait_out();
      chk(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
      chk(out_stamp == m_st[k], {tag, " stamp"}, out_stamp, m_st[k]);
      chk(out_data == m_dt[k], {tag, " payload"}, out_data, m_dt[k]);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, {tag, " empty after drain"}, out_valid, 0);
    chk(ahead_err == 1'b0, "R10 no flag when time is past stamps", ahead_err, 0);
    m_n = 0;
  endtask

  task automatic gate_case(input logic [63:0] s, d, e, l, t, input string tag);
    logic [67:0] w;
    logic [67:0] thr;
    do_reset(s, d, e, l);
    push(t, 16'h77);
    w   = {4'b0, t} + {4'b0, s} + {4'b0, d} + {4'b0, e};
    thr = (w >= {4'b0, l}) ? (w - {4'b0, l}) : 68'd0;
    now_time = thr[63:0];
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, {tag, " held at bound"}, out_valid, 0);
    now_time = thr[63:0] + 64'd1;
    @(negedge clk);
    chk(out_valid == 1'b1, {tag, " released above bound"}, out_valid, 1);
    chk(out_stamp == t, {tag, " stamp"}, out_stamp, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    do_reset(0, 0, 0, 0);
    // R1
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(order_err == 1'b0, "R1 order_err", order_err, 0);
    chk(ahead_err == 1'b0, "R1 ahead_err", ahead_err, 0);

    // R2 ascending, descending; R6 full
    for (int k = 0; k < DEPTH; k++) fill(64'(k + 1), 16'(k));
    chk(in_ready == 1'b0, "R6 full ascending", in_ready, 0);
    drain_check("R2 ascending");
    chk(in_ready == 1'b1, "R6 ready after drain", in_ready, 1);

    do_reset(0, 0, 0, 0);
    for (int k = 0; k < DEPTH; k++) fill(64'(DEPTH - k), 16'(k));
    chk(in_ready == 1'b0, "R6 full descending", in_ready, 0);
    drain_check("R2 descending");

    // R3 ties
    do_reset(0, 0, 0, 0);
    fill(5, 0); fill(3, 1); fill(5, 2); fill(3, 3);
    fill(5, 4); fill(1, 5); fill(1, 6); fill(5, 7);
    drain_check("R3 ties");

    // R2 / R3 pseudo-random rounds
    for (int r = 0; r < 24; r++) begin
      do_reset(0, 0, 0, 0);
      for (int k = 0; k < DEPTH; k++) fill(64'((r * 37 + k * 13 + k * k * 7) % 9), 16'(r * 16 + k));
      chk(in_ready == 1'b0, "R6 full random", in_ready, 0);
      drain_check("R2 R3 random");
    end

    // R4 gate sweep, including wide-sum overflow; R5 saturation
    gate_case(3, 4, 2, 5, 40, "R4 mixed");
    gate_case(0, 0, 0, 0, 40, "R4 zero bounds");
    gate_case(7, 1, 1, 2, 40, "R4 positive");
    gate_case(10, 20, 30, 0, 40, "R4 no latency");
    gate_case(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 40, "R4 wide sum");
    gate_case(0, 0, 0, 10, 2, "R5 saturate");
    gate_case(0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 7, "R5 saturate max");

    // R9 bounds frozen while holding an event
    do_reset(3, 4, 2, 5);
    push(20, 16'h1);
    cfg_l = 100;
    now_time = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 new bounds ignored while held", out_valid, 0);
    now_time = 24;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9 old bound still applies", out_valid, 0);
    now_time = 25;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_stamp == 20, "R9 released by old bound", out_stamp, 20);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    now_time = 0;
    @(negedge clk);
    push(30, 16'h2);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9 new bound held at zero", out_valid, 0);
    now_time = 1;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_stamp == 30, "R9 new bound taken when empty", out_stamp, 30);

    // R8 stall
    do_reset(0, 0, 0, 0);
    push(50, 16'hA); push(60, 16'hB);
    now_time = 1000;
    wait_out();
    for (int k = 0; k < 4; k++) begin
      chk(out_valid == 1'b1 && out_stamp == 50 && out_data == 16'hA, "R8 held while stalled", out_stamp, 50);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_stamp == 60 && out_data == 16'hB, "R8 next after accept", out_stamp, 60);
    @(negedge clk);
    out_ready = 1'b0;

    // R7 late input
    chk(order_err == 1'b0, "R7 flag clear before", order_err, 0);
    push(55, 16'hC);
    chk(order_err == 1'b1, "R7 flag set", order_err, 1);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 late event discarded", out_valid, 0);
    push(70, 16'hD);
    wait_out();
    chk(out_valid == 1'b1 && out_stamp == 70, "R7 later event passes", out_stamp, 70);
    @(negedge clk);
    chk(order_err == 1'b1, "R7 flag sticky", order_err, 1);
    out_ready = 1'b0;

    // R7 same-edge: head leaving while smaller stamp arrives
    do_reset(0, 0, 0, 0);
    push(80, 16'h1);
    now_time = 1000;
    in_stamp = 75; in_data = 16'h2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(order_err == 1'b1, "R7 same-edge flag", order_err, 1);
    out_ready = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R7 same-edge discarded", out_valid, 0);
    out_ready = 1'b0;

    // R10 early hand-out
    do_reset(0, 0, 0, 5);
    push(100, 16'h5);
    now_time = 96;
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 released early", out_valid, 1);
    chk(ahead_err == 1'b0, "R10 no flag before accept", ahead_err, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(ahead_err == 1'b1, "R10 flag on accept", ahead_err, 1);
    repeat (2) @(negedge clk);
    chk(ahead_err == 1'b1, "R10 flag sticky", ahead_err, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule